// File: doc/BRIEF.md
# Static Icon Backplane and Frontplane Driver

This block drives a small static-icon display made of one shared backplane and three independent icon segments (frontplanes). It divides the display oscillator clock down to a slow square wave with a 50% duty cycle and puts that wave on the backplane. Each frontplane carries the same wave, either unchanged or inverted. An icon that is off gets the in-phase copy, so its segment sees no voltage. An icon that is on gets the inverted copy, so its segment sees the full swing.

Software controls the icons with single-byte commands. Each command arrives as a one-cycle strobe in the system clock domain. The block hands the command across into the oscillator domain through a toggle synchronizer, decodes it there, and updates one icon's state. A level input enables the oscillator. When it is low, the backplane, the frontplanes and the divider all stop and rest at zero. All outputs also rest at zero while every icon is off.

The command strobes must be at least four oscillator cycles apart, because the toggle handshake carries only one command at a time.

Top module: `annun_wave_gen`

## Requirements
- R1: While `osc_en` is high, `bp_out` is a square wave with a period of `DIV_RATIO` oscillator cycles. It is high for exactly `DIV_RATIO/2` cycles and low for exactly `DIV_RATIO/2` cycles (1280 by default, 30 Hz from 38.4 kHz).
- R2: While at least one icon is on, the frontplane of each icon that is off equals `bp_out` in every oscillator cycle.
- R3: While at least one icon is on, the frontplane of each icon that is on equals the inverse of `bp_out` in every oscillator cycle.
- R4: While all icons are off, `fp_out` is held at 0.
- R5: One oscillator edge after `osc_en` is sampled low, `bp_out` and `fp_out` are both 0, and they stay 0 while it remains low.
- R6: Only a byte whose bits [7:3] are 01100 is accepted as an icon command. Bits [2:1] select the icon: 00 selects `fp_out[0]`, 01 selects `fp_out[1]`, 10 selects `fp_out[2]`. Bit [0] sets the selected icon on (1) or off (0). Any other byte changes no state.
- R7: An icon command with bits [2:1] = 11 changes no icon state.
- R8: After reset, all icons are off and `bp_out` and `fp_out` are 0.
- R9: The divider restarts from zero phase when the oscillator is disabled. After `osc_en` returns high, `bp_out` first rises on the `DIV_RATIO/2`-th oscillator edge at which `osc_en` is sampled high.
- R10: A command strobed on `cmd_valid` shows at `fp_out` by the fourth oscillator edge after the system-clock edge that captured it. Icon state is kept while the oscillator is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the command input |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| cmd_valid | input | 1 | One-cycle strobe: `cmd_byte` holds a command |
| cmd_byte | input | 8 | Command byte |
| osc_clk | input | 1 | Display oscillator clock |
| osc_rst | input | 1 | Synchronous active-high reset, oscillator domain |
| osc_en | input | 1 | Oscillator enable, oscillator domain |
| bp_out | output | 1 | Backplane square wave |
| fp_out | output | 3 | Frontplane waves, one per icon |

## Verification
A wrong divider count shows up as a high or low run of `bp_out` that is longer or shorter than half the period. That is visible within one backplane period, and it also breaks the restart timing after re-enable. A wrong icon state bit appears at the port within four oscillator edges of the command as a frontplane with the wrong polarity against `bp_out`. It stays there on every sample until the next command, so each comparison window over a full period exposes it. Decode faults, such as a wrong opcode match or the reserved select code leaking through, change a frontplane's polarity and are caught in the same way.

// File: rtl/annun_pkg.sv
package annun_pkg;
  localparam int unsigned ICON_COUNT = 3;
  localparam logic [4:0]  ICON_OPCODE = 5'b01100;

  typedef struct packed {
    logic [4:0] opcode;
    logic [1:0] sel;
    logic       state;
  } icon_cmd_t;
endpackage

// File: rtl/annun_cmd_sync.sv
module annun_cmd_sync #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CMD_W       = 8
) (
  input  logic             sys_clk,
  input  logic             sys_rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic             osc_clk,
  input  logic             osc_rst,
  output logic             cmd_pulse,
  output logic [CMD_W-1:0] cmd_data
);
  logic [CMD_W-1:0]     hold_q;
  logic                 tog_q;
  logic [SYNC_STAGES:0] sync_q;

  // system side: hold the byte and flip the request flag
  always_ff @(posedge sys_clk) begin
    if (sys_rst) begin
      hold_q <= '0;
      tog_q  <= 1'b0;
    end else if (cmd_valid) begin
      hold_q <= cmd_byte;
      tog_q  <= ~tog_q;
    end
  end

  // oscillator side: synchronizer chain plus one stage for edge detection
  always_ff @(posedge osc_clk) begin
    if (osc_rst) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], tog_q};
  end

  assign cmd_pulse = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
  assign cmd_data  = hold_q;

  AST_PULSE_SINGLE: assert property (@(posedge osc_clk) disable iff (osc_rst) cmd_pulse |=> !cmd_pulse) else $error("command pulse longer than one cycle"); // R10
endmodule

// File: rtl/annun_icon_regs.sv
module annun_icon_regs #(
  parameter int unsigned ICONS = annun_pkg::ICON_COUNT
) (
  input  logic             osc_clk,
  input  logic             osc_rst,
  input  logic             cmd_pulse,
  input  logic [7:0]       cmd_data,
  output logic [ICONS-1:0] icon_on
);
  import annun_pkg::*;

  icon_cmd_t cmd;
  logic      hit;

  assign cmd = icon_cmd_t'(cmd_data);
  assign hit = cmd_pulse && (cmd.opcode == ICON_OPCODE);

  for (genvar i = 0; i < ICONS; i++) begin : g_icon
    always_ff @(posedge osc_clk) begin
      if (osc_rst)                     icon_on[i] <= 1'b0;
      else if (hit && cmd.sel == 2'(i)) icon_on[i] <= cmd.state;
    end
  end

  AST_RESERVED_SEL_KEEPS: assert property (@(posedge osc_clk) disable iff (osc_rst) (cmd_pulse && cmd.sel == 2'd3) |=> $stable(icon_on)) else $error("reserved select changed state"); // R7
  AST_FOREIGN_OPCODE_KEEPS: assert property (@(posedge osc_clk) disable iff (osc_rst) (cmd_pulse && cmd.opcode != ICON_OPCODE) |=> $stable(icon_on)) else $error("foreign command changed state"); // R6
endmodule

// File: rtl/annun_divider.sv
module annun_divider #(
  parameter int unsigned DIV_RATIO = 1280
) (
  input  logic osc_clk,
  input  logic osc_rst,
  input  logic osc_en,
  output logic phase_next,
  output logic phase_q
);
  localparam int unsigned HALF  = DIV_RATIO / 2;
  localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ph_d;

  always_comb begin
    if (!osc_en) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
      ph_d  = ~phase_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
      ph_d  = phase_q;
    end
  end

  always_ff @(posedge osc_clk) begin
    if (osc_rst) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= ph_d;
    end
  end

  assign phase_next = ph_d;

  AST_CNT_IN_RANGE: assert property (@(posedge osc_clk) disable iff (osc_rst) cnt_q <= LAST) else $error("divider count out of range"); // R1
  AST_PHASE_AT_WRAP: assert property (@(posedge osc_clk) disable iff (osc_rst) (phase_q != $past(phase_q)) |-> (cnt_q == '0)) else $error("phase moved off the wrap point"); // R1
endmodule

// File: rtl/annun_wave_gen.sv
module annun_wave_gen #(
  parameter int unsigned DIV_RATIO   = 1280,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ICONS       = annun_pkg::ICON_COUNT
) (
  input  logic             sys_clk,
  input  logic             sys_rst,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  input  logic             osc_clk,
  input  logic             osc_rst,
  input  logic             osc_en,
  output logic             bp_out,
  output logic [ICONS-1:0] fp_out
);
  logic             cmd_pulse;
  logic [7:0]       cmd_data;
  logic [ICONS-1:0] icon_on;
  logic             phase_next;
  logic             any_on;

  annun_cmd_sync #(.SYNC_STAGES(SYNC_STAGES), .CMD_W(8)) u_sync (
    .sys_clk   (sys_clk),
    .sys_rst   (sys_rst),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .osc_clk   (osc_clk),
    .osc_rst   (osc_rst),
    .cmd_pulse (cmd_pulse),
    .cmd_data  (cmd_data)
  );

  annun_icon_regs #(.ICONS(ICONS)) u_icons (
    .osc_clk   (osc_clk),
    .osc_rst   (osc_rst),
    .cmd_pulse (cmd_pulse),
    .cmd_data  (cmd_data),
    .icon_on   (icon_on)
  );

  annun_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
    .osc_clk    (osc_clk),
    .osc_rst    (osc_rst),
    .osc_en     (osc_en),
    .phase_next (phase_next),
    .phase_q    (bp_out)
  );

  assign any_on = |icon_on;

  // frontplanes register from the same next phase as the backplane
  for (genvar i = 0; i < ICONS; i++) begin : g_fp
    always_ff @(posedge osc_clk) begin
      if (osc_rst)                fp_out[i] <= 1'b0;
      else if (osc_en && any_on)  fp_out[i] <= phase_next ^ icon_on[i];
      else                        fp_out[i] <= 1'b0;
    end
  end

  AST_IDLE_WHEN_STOPPED: assert property (@(posedge osc_clk) disable iff (osc_rst) !osc_en |=> (bp_out == 1'b0 && fp_out == '0)) else $error("outputs active while stopped"); // R5
  AST_ALL_OFF_QUIET: assert property (@(posedge osc_clk) disable iff (osc_rst) (icon_on == '0) |=> (fp_out == '0)) else $error("frontplane active with all icons off"); // R4
endmodule

// File: tb/annun_wave_gen_bench.sv
module annun_wave_gen_bench;
  localparam int unsigned DIV  = 40;
  localparam int unsigned HALF = DIV / 2;

  logic       sys_clk = 1'b0;
  logic       osc_clk = 1'b0;
  logic       sys_rst = 1'b1;
  logic       osc_rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       osc_en = 1'b1;
  logic       bp_out;
  logic [2:0] fp_out;

  int checks = 0;
  int errors = 0;
  logic [2:0] on_exp = 3'b000;

  always #2.5 sys_clk = ~sys_clk;
  always #18 osc_clk = ~osc_clk;

  annun_wave_gen #(.DIV_RATIO(DIV)) u_annun_wave_gen (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .osc_clk(osc_clk), .osc_rst(osc_rst), .osc_en(osc_en),
    .bp_out(bp_out), .fp_out(fp_out)
  );

  function automatic logic [2:0] fp_model(input logic bp, input logic [2:0] on);
    if (on == 3'b000) return 3'b000;
    return {3{bp}} ^ on;
  endfunction

  function automatic logic [2:0] apply_cmd(input logic [7:0] b, input logic [2:0] on);
    logic [2:0] r = on;
    if (b[7:3] == 5'b01100 && b[2:1] != 2'b11) r[b[2:1]] = b[0];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic strobe(input logic [7:0] b);
    @(negedge sys_clk);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    @(negedge sys_clk);
    cmd_valid = 1'b0;
    on_exp = apply_cmd(b, on_exp);
  endtask

  task automatic send(input logic [7:0] b);
    strobe(b);
    repeat (8) @(negedge osc_clk);
  endtask

  task automatic window(input int n, input string tag);
    int bad = 0;
    logic [2:0] a = 3'b000, e = 3'b000;
    for (int k = 0; k < n; k++) begin
      @(negedge osc_clk);
      if (fp_out !== fp_model(bp_out, on_exp)) begin
        if (bad == 0) begin a = fp_out; e = fp_model(bp_out, on_exp); end
        bad++;
      end
    end
    check(bad == 0, tag, int'(a), int'(e));
  endtask

  initial begin
    logic [7:0] b;
    int hi, lo, rise;
    void'($urandom(32'd5171));
    repeat (4) @(negedge osc_clk);
    osc_rst = 1'b0;
    @(negedge sys_clk);
    sys_rst = 1'b0;
    repeat (3) @(negedge osc_clk);
    // R8: idle after reset
    check(bp_out == 1'b0 && fp_out == 3'b000, "R8 reset outputs", int'({bp_out, fp_out}), 0);

    // R4: all off keeps frontplanes at zero
    window(2 * DIV, "R4 all off");

    // R1: run lengths of the backplane
    while (bp_out !== 1'b1) @(negedge osc_clk);
    hi = 0;
    while (bp_out === 1'b1 && hi < 4 * DIV) begin hi++; @(negedge osc_clk); end
    lo = 0;
    while (bp_out === 1'b0 && lo < 4 * DIV) begin lo++; @(negedge osc_clk); end
    check(hi == HALF, "R1 high run", hi, HALF);
    check(lo == HALF, "R1 low run", lo, HALF);

    // R2 R3: icon 1 on, others off
    send(8'b0110_0011);
    window(2 * DIV, "R2 R3 icon1 on");

    // R10: latency bound
    strobe(8'b0110_0001);
    repeat (5) @(negedge osc_clk);
    check(fp_out === fp_model(bp_out, on_exp), "R10 latency", int'(fp_out), int'(fp_model(bp_out, on_exp)));
    window(DIV, "R10 settled");

    // R7: reserved select ignored
    send(8'b0110_0111);
    window(2 * DIV, "R7 reserved select");
    send(8'b0110_0110);
    window(DIV, "R7 reserved off");

    // R6: foreign opcode ignored
    send(8'b0111_0000);
    send(8'b1110_0010);
    window(2 * DIV, "R6 foreign opcode");

    // R5: oscillator disabled
    @(negedge osc_clk);
    osc_en = 1'b0;
    @(negedge osc_clk);
    check(bp_out == 1'b0 && fp_out == 3'b000, "R5 stop edge", int'({bp_out, fp_out}), 0);
    repeat (DIV) @(negedge osc_clk);
    check(bp_out == 1'b0 && fp_out == 3'b000, "R5 stopped", int'({bp_out, fp_out}), 0);

    // R9: restart phase
    osc_en = 1'b1;
    rise = 0;
    for (int k = 1; k <= 2 * DIV; k++) begin
      @(negedge osc_clk);
      if (rise == 0 && bp_out === 1'b1) rise = k;
    end
    check(rise == HALF, "R9 restart rise", rise, HALF);
    window(DIV, "R10 state kept over stop");

    // R6: random mix of icon commands and other bytes
    for (int it = 0; it < 20; it++) begin
      if (($urandom % 4) != 0) b = {5'b01100, 2'($urandom % 4), 1'($urandom % 2)};
      else                     b = 8'($urandom % 256);
      send(b);
      window(DIV + 5, "R6 random command");
    end

    // R4: everything off again
    send(8'b0110_0000);
    send(8'b0110_0010);
    send(8'b0110_0100);
    window(2 * DIV, "R4 all off again");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge sys_clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule